// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits on the command path between an SDRAM controller's command generator and the memory pins. It tracks the open or closed state of each bank and a set of countdown timers. For every proposed command it decides whether the command can go out now without breaking a minimum spacing rule. A command that is legal passes straight through in the same cycle. A command that would violate a rule is dropped, and an error flag is raised for that cycle.

Spacing limits given in nanoseconds are turned into clock cycles at elaboration time. Each limit is divided by the clock-period parameter and rounded up to a whole cycle. Limits tied to the data burst are computed at run time from the configured CAS latency and burst length. The guard also watches how long each bank has been open. Once a bank has been open for the maximum active time, the guard asks for that bank to be precharged.

Commands are coded as NOP=0, ACT (activate)=1, RD=2, WR=3, PRE (precharge one bank)=4, REF (auto refresh)=5, MRS (mode register set)=6 and BST (burst stop)=7. The ready vector carries one bit per code, and bit i gives the readiness of code i on the bank currently shown on `cmd_bank`.

Top module: `sdram_cmd_guard`

## Requirements
- R1: After reset, every bank is closed and no precharge request is raised. In the ready vector, NOP, ACT and REF read 1 and RD reads 0.
- R2: Each nanosecond limit becomes ceil(limit_ns / CLK_NS) cycles. For example, 50 ns at an 8 ns clock gives 7 cycles.
- R3: RD or WR to a bank is ready no earlier than tRCD cycles after that bank's ACT.
- R4: ACT to any bank is ready no earlier than tRRD cycles after the previous ACT.
- R5: PRE to a bank is ready no earlier than tRAS cycles after its ACT. A new ACT to the same bank needs both tRC cycles since the last ACT and tRP cycles since its PRE.
- R6: After a WR of burst length BL issued in cycle t, PRE to that bank is ready no earlier than cycle t+BL+1. That is two clocks after the last write data.
- R7: After a RD issued in cycle t, PRE to that bank is ready no earlier than cycle t+max(CL+BL-2,1).
- R8: Column commands (RD, WR) to an open bank are accepted on consecutive clocks.
- R9: After a WR of burst length BL issued in cycle t, BST is ready no earlier than cycle t+BL.
- R10: REF and MRS need every bank closed and past its precharge and row-cycle limits. After MRS, both ACT and REF wait 2 cycles. After REF, ACT, REF and MRS wait tRFC cycles.
- R11: A command presented while its ready bit is 0 raises `cmd_err` in that cycle, is not passed on, and leaves the bank state unchanged.
- R12: `pre_req[b]` rises tRASmax cycles after bank b's ACT while the bank is still open, and falls after the bank is precharged.
- R13: An accepted command other than NOP shows up on `out_valid`, `out_op` and `out_bank` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat | input | 2 | CAS latency, 2 or 3 |
| burst_len | input | BLW | Burst length in beats, 1 to 8 |
| cmd_valid | input | 1 | Proposed command present |
| cmd_op | input | 3 | Command code |
| cmd_bank | input | BANK_W | Target bank |
| rdy_vec | output | 8 | Readiness of each command code for `cmd_bank` |
| cmd_ready | output | 1 | Readiness of the presented code |
| cmd_err | output | 1 | Command presented while not ready |
| out_valid | output | 1 | Legal command issued to the memory |
| out_op | output | 3 | Issued command code |
| out_bank | output | BANK_W | Issued bank |
| pre_req | output | NBANK | Per-bank must-precharge request |

## Verification
The properties assume a few things about the inputs. `cas_lat` is 2 or 3, `burst_len` is between 1 and 8, `cmd_valid` is low during reset, and the configuration does not change while a burst-dependent timer is running. The stimulus meets these assumptions in three ways. It sets the configuration only right after a reset, it sweeps burst length and latency across their legal values, and it resets the block before every measured interval. Each measured interval therefore begins from closed banks and timers at zero. The readiness probes are taken with `cmd_valid` low, so a probe cannot disturb the state it is measuring.

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard #(
  parameter int NBANK        = 4,
  parameter int BANK_W       = $clog2(NBANK),
  parameter int BLW          = 4,
  parameter int CLK_NS       = 8,
  parameter int T_RRD_NS     = 15,
  parameter int T_RCD_NS     = 15,
  parameter int T_RP_NS      = 15,
  parameter int T_RAS_NS     = 48,
  parameter int T_RASMAX_NS  = 100000,
  parameter int T_RC_NS      = 63,
  parameter int T_RFC_NS     = 80,
  parameter int T_RDL_CLK    = 2,
  parameter int T_BDL_CLK    = 1,
  parameter int T_MRD_CLK    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cas_lat,
  input  logic [BLW-1:0]    burst_len,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic [7:0]        rdy_vec,
  output logic              cmd_ready,
  output logic              cmd_err,
  output logic              out_valid,
  output logic [2:0]        out_op,
  output logic [BANK_W-1:0] out_bank,
  output logic [NBANK-1:0]  pre_req
);

  localparam logic [2:0] OP_NOP = 3'd0, OP_ACT = 3'd1, OP_RD  = 3'd2, OP_WR  = 3'd3,
                         OP_PRE = 3'd4, OP_REF = 3'd5, OP_MRS = 3'd6, OP_BST = 3'd7;

  function automatic int to_clk(input int ns);
    int r;
    r = (ns + CLK_NS - 1) / CLK_NS;
    return (r < 1) ? 1 : r;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RRD_C    = to_clk(T_RRD_NS);
  localparam int RCD_C    = to_clk(T_RCD_NS);
  localparam int RP_C     = to_clk(T_RP_NS);
  localparam int RAS_C    = to_clk(T_RAS_NS);
  localparam int RASMAX_C = to_clk(T_RASMAX_NS);
  localparam int RC_C     = to_clk(T_RC_NS);
  localparam int RFC_C    = to_clk(T_RFC_NS);
  localparam int BLMAX    = (1 << BLW) - 1;
  localparam int TOP      = imax(imax(imax(RC_C, RFC_C), imax(RAS_C, RRD_C)),
                                 imax(imax(RCD_C, RP_C), BLMAX + 4 + T_RDL_CLK + T_BDL_CLK + T_MRD_CLK));
  localparam int TW       = $clog2(TOP + 1);
  localparam int MW       = $clog2(RASMAX_C + 1);

  function automatic logic [TW-1:0] dn(input logic [TW-1:0] v);
    return (v == '0) ? v : v - TW'(1);
  endfunction

  logic             accept;
  logic [NBANK-1:0] b_open, b_act_ok, b_col_ok, b_pre_ok, b_idle_ok;
  logic [TW-1:0]    rrd_q, rfc_q, mrd_q, bst_q;
  logic [TW-1:0]    rd_load, wr_load, bst_load;
  int               rd_n, wr_n, bst_n;

  always_comb begin
    rd_n  = int'(cas_lat) + int'(burst_len) - 3;
    wr_n  = int'(burst_len) + T_RDL_CLK - 2;
    bst_n = int'(burst_len) + T_BDL_CLK - 2;
    if (rd_n < 0)  rd_n  = 0;
    if (wr_n < 0)  wr_n  = 0;
    if (bst_n < 0) bst_n = 0;
    rd_load  = TW'(rd_n);
    wr_load  = TW'(wr_n);
    bst_load = TW'(bst_n);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic          open_q;
    logic [TW-1:0] rcd_q, rp_q, ras_q, rc_q, wr_q, rdp_q;
    logic [MW-1:0] rmax_q;
    logic          hit;

    assign hit = accept && (cmd_bank == BANK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        rcd_q <= '0; rp_q <= '0; ras_q <= '0; rc_q <= '0; wr_q <= '0; rdp_q <= '0;
        rmax_q <= '0;
      end else begin
        rcd_q <= dn(rcd_q); rp_q <= dn(rp_q); ras_q <= dn(ras_q);
        rc_q  <= dn(rc_q);  wr_q <= dn(wr_q); rdp_q <= dn(rdp_q);
        if (rmax_q != '0) rmax_q <= rmax_q - MW'(1);
        if (hit) begin
          case (cmd_op)
            OP_ACT: begin
              open_q <= 1'b1;
              rcd_q  <= TW'(RCD_C - 1);
              ras_q  <= TW'(RAS_C - 1);
              rc_q   <= TW'(RC_C - 1);
              rmax_q <= MW'(RASMAX_C - 1);
            end
            OP_RD: rdp_q <= rd_load;
            OP_WR: wr_q  <= wr_load;
            OP_PRE: if (open_q) begin
              open_q <= 1'b0;
              rp_q   <= TW'(RP_C - 1);
            end
            default: ;
          endcase
        end
      end
    end

    assign b_open[b]    = open_q;
    assign b_idle_ok[b] = !open_q && rp_q == '0 && rc_q == '0;
    assign b_act_ok[b]  = b_idle_ok[b];
    assign b_col_ok[b]  = open_q && rcd_q == '0;
    assign b_pre_ok[b]  = !open_q || (ras_q == '0 && wr_q == '0 && rdp_q == '0);
    assign pre_req[b]   = open_q && rmax_q == '0;
  end

  wire glob_row_ok = (rfc_q == '0) && (mrd_q == '0);
  wire all_idle    = &b_idle_ok;

  assign rdy_vec[OP_NOP] = 1'b1;
  assign rdy_vec[OP_ACT] = b_act_ok[cmd_bank] && rrd_q == '0 && glob_row_ok;
  assign rdy_vec[OP_RD]  = b_col_ok[cmd_bank];
  assign rdy_vec[OP_WR]  = b_col_ok[cmd_bank];
  assign rdy_vec[OP_PRE] = b_pre_ok[cmd_bank];
  assign rdy_vec[OP_REF] = all_idle && glob_row_ok;
  assign rdy_vec[OP_MRS] = all_idle && glob_row_ok;
  assign rdy_vec[OP_BST] = bst_q == '0;

  assign cmd_ready = rdy_vec[cmd_op];
  assign accept    = cmd_valid && cmd_ready;
  assign cmd_err   = cmd_valid && !cmd_ready;
  assign out_valid = accept && (cmd_op != OP_NOP);
  assign out_op    = cmd_op;
  assign out_bank  = cmd_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_q <= '0; rfc_q <= '0; mrd_q <= '0; bst_q <= '0;
    end else begin
      rrd_q <= dn(rrd_q); rfc_q <= dn(rfc_q); mrd_q <= dn(mrd_q); bst_q <= dn(bst_q);
      if (accept) begin
        case (cmd_op)
          OP_ACT: rrd_q <= TW'(RRD_C - 1);
          OP_REF: rfc_q <= TW'(RFC_C - 1);
          OP_MRS: mrd_q <= TW'(T_MRD_CLK - 1);
          OP_WR:  bst_q <= bst_load;
          default: ;
        endcase
      end
    end
  end

  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> $stable(b_open)); // R11

  AST_REF_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == OP_REF) |=> !(out_valid && (out_op == OP_RD || out_op == OP_WR))); // R10

  if (RRD_C > 1) begin : g_a_rrd
    AST_RRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_op == OP_ACT) |=> !(out_valid && out_op == OP_ACT)); // R4
  end
  if (RCD_C > 1) begin : g_a_rcd
    AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_op == OP_ACT) |=>
        !(out_valid && (out_op == OP_RD || out_op == OP_WR) && out_bank == $past(out_bank))); // R3
  end
  if (RAS_C > 1) begin : g_a_ras
    AST_RAS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_op == OP_ACT) |=> !(out_valid && out_op == OP_PRE && out_bank == $past(out_bank))); // R5
  end
  if (T_MRD_CLK > 1) begin : g_a_mrd
    AST_MRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_op == OP_MRS) |=> !(out_valid && (out_op == OP_ACT || out_op == OP_REF))); // R10
  end
  if (RASMAX_C > 1) begin : g_a_rmax
    AST_PREREQ_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_op == OP_ACT) |=> !pre_req[$past(out_bank)]); // R12
  end

endmodule

// File: tb/sdram_cmd_guard_tb.sv
`timescale 1ns/1ps
module sdram_cmd_guard_tb;
  localparam int NB = 4, BW = 2, BLW = 4, CK = 8;
  localparam int RRD_NS = 20, RCD_NS = 20, RP_NS = 20, RAS_NS = 50, RC_NS = 90, RFC_NS = 80, RMAX_NS = 400;
  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, REF = 5, MRS = 6, BST = 7;

  function automatic int cyc_of(input int ns);
    return (ns + CK - 1) / CK;
  endfunction

  logic clk = 0, rst_n = 0;
  logic [1:0] cas_lat = 2'd3;
  logic [BLW-1:0] burst_len = 4'd4;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = 3'd0;
  logic [BW-1:0] cmd_bank = '0;
  logic [7:0] rdy_vec;
  logic cmd_ready, cmd_err, out_valid;
  logic [2:0] out_op;
  logic [BW-1:0] out_bank;
  logic [NB-1:0] pre_req;

  sdram_cmd_guard #(.NBANK(NB), .BLW(BLW), .CLK_NS(CK), .T_RRD_NS(RRD_NS), .T_RCD_NS(RCD_NS),
    .T_RP_NS(RP_NS), .T_RAS_NS(RAS_NS), .T_RASMAX_NS(RMAX_NS), .T_RC_NS(RC_NS), .T_RFC_NS(RFC_NS))
  u_dut (.clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .burst_len(burst_len), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .rdy_vec(rdy_vec), .cmd_ready(cmd_ready), .cmd_err(cmd_err),
    .out_valid(out_valid), .out_op(out_op), .out_bank(out_bank), .pre_req(pre_req));

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    cmd_valid = 0; cmd_op = 3'(NOP); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic issue(input int op, input int bank, input string tag, output int t);
    cmd_op = 3'(op); cmd_bank = BW'(bank); cmd_valid = 1;
    #1;
    chk({tag, " out_valid"}, out_valid, 1);
    chk({tag, " out_op"}, out_op, op);
    chk({tag, " out_bank"}, out_bank, bank);
    t = cyc;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 3'(NOP);
  endtask

  task automatic probe(input int op, input int bank, input int exp, input string tag);
    cmd_bank = BW'(bank);
    #1;
    chk(tag, rdy_vec[op], exp);
  endtask

  task automatic wait_to(input int t0, input int d);
    while (cyc - t0 < d) @(negedge clk);
  endtask

  task automatic sweep(input string tag, input int t0, input int op, input int bank,
                       input int n, input int lo, input int hi);
    for (int d = lo; d <= hi; d++) begin
      wait_to(t0, d);
      probe(op, bank, (d >= n) ? 1 : 0, tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t0, t1;
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 pre_req", int'(pre_req), 0);
    probe(NOP, 0, 1, "R1 nop");
    probe(ACT, 0, 1, "R1 act");
    probe(RD, 0, 0, "R1 rd");
    probe(REF, 0, 1, "R1 ref");

    // R3 activate to column
    do_reset();
    issue(ACT, 0, "R13", t0);
    sweep("R3 rd", t0, RD, 0, cyc_of(RCD_NS), 1, 5);
    do_reset();
    issue(ACT, 3, "R13", t0);
    sweep("R3 wr", t0, WR, 3, cyc_of(RCD_NS), 1, 5);

    // R4 activate spacing across banks
    do_reset();
    issue(ACT, 0, "R13", t0);
    sweep("R4", t0, ACT, 1, cyc_of(RRD_NS), 1, 5);

    // R5 / R2 active time (50 ns -> 7 cycles)
    do_reset();
    issue(ACT, 1, "R13", t0);
    sweep("R5 R2 ras", t0, PRE, 1, cyc_of(RAS_NS), 1, 9);

    // R5 row cycle
    do_reset();
    issue(ACT, 0, "R13", t0);
    wait_to(t0, cyc_of(RAS_NS));
    issue(PRE, 0, "R5 pre", t1);
    sweep("R5 rc", t0, ACT, 0, cyc_of(RC_NS), 8, 14);

    // R5 precharge period
    do_reset();
    issue(ACT, 0, "R13", t0);
    wait_to(t0, cyc_of(RC_NS) - 1);
    issue(PRE, 0, "R5 pre", t1);
    sweep("R5 rp", t1, ACT, 0, cyc_of(RP_NS), 1, 4);

    // R6 write recovery and R9 burst stop, across burst lengths
    for (int k = 0; k < 4; k++) begin
      int bl, tw;
      bl = 1 << k;
      burst_len = BLW'(bl);
      do_reset();
      issue(ACT, 2, "R13", t0);
      wait_to(t0, 8);
      issue(WR, 2, "R13", tw);
      for (int d = 1; d <= bl + 3; d++) begin
        wait_to(tw, d);
        probe(PRE, 2, (d >= bl + 1) ? 1 : 0, $sformatf("R6 bl=%0d d=%0d", bl, d));
        probe(BST, 2, (d >= bl) ? 1 : 0, $sformatf("R9 bl=%0d d=%0d", bl, d));
      end
    end

    // R7 read to precharge, across latency and burst length
    for (int cl = 2; cl <= 3; cl++) begin
      for (int k = 0; k < 4; k++) begin
        int bl, tr, n;
        bl = 1 << k;
        n = (cl + bl - 2 > 1) ? cl + bl - 2 : 1;
        cas_lat = 2'(cl);
        burst_len = BLW'(bl);
        do_reset();
        issue(ACT, 1, "R13", t0);
        wait_to(t0, 8);
        issue(RD, 1, "R13", tr);
        sweep($sformatf("R7 cl=%0d bl=%0d", cl, bl), tr, PRE, 1, n, 1, n + 2);
      end
    end
    cas_lat = 2'd3; burst_len = 4'd4;

    // R8 back-to-back column commands
    do_reset();
    issue(ACT, 0, "R13", t0);
    wait_to(t0, cyc_of(RCD_NS));
    issue(RD, 0, "R8 rd", t1);
    issue(WR, 0, "R8 wr next", t1);
    issue(RD, 0, "R8 rd next", t1);

    // R10 mode register set spacing
    do_reset();
    issue(MRS, 0, "R13", t0);
    sweep("R10 mrs->act", t0, ACT, 2, 2, 1, 3);
    do_reset();
    issue(MRS, 0, "R13", t0);
    sweep("R10 mrs->ref", t0, REF, 0, 2, 1, 3);

    // R10 refresh spacing
    do_reset();
    issue(REF, 0, "R13", t0);
    sweep("R10 ref->act", t0, ACT, 1, cyc_of(RFC_NS), 1, 11);
    do_reset();
    issue(REF, 0, "R13", t0);
    sweep("R10 ref->mrs", t0, MRS, 1, cyc_of(RFC_NS), 8, 11);

    // R10 refresh needs all banks closed
    do_reset();
    issue(ACT, 3, "R13", t0);
    wait_to(t0, 20);
    probe(REF, 0, 0, "R10 ref open bank");
    probe(MRS, 0, 0, "R10 mrs open bank");

    // R11 illegal commands
    do_reset();
    cmd_op = 3'(RD); cmd_bank = 2'd1; cmd_valid = 1;
    #1;
    chk("R11 err", cmd_err, 1);
    chk("R11 no pass", out_valid, 0);
    @(negedge clk);
    cmd_valid = 0;
    probe(RD, 1, 0, "R11 still closed rd");
    probe(ACT, 1, 1, "R11 still closed act");
    issue(ACT, 1, "R13", t0);
    wait_to(t0, 4);
    cmd_op = 3'(ACT); cmd_bank = 2'd1; cmd_valid = 1;
    #1;
    chk("R11 act on open", cmd_err, 1);
    chk("R11 act no pass", out_valid, 0);
    @(negedge clk);
    cmd_valid = 0;
    probe(RD, 1, 1, "R11 still open");

    // R12 maximum active time
    do_reset();
    issue(ACT, 2, "R13", t0);
    wait_to(t0, cyc_of(RMAX_NS) - 1);
    chk("R12 before", int'(pre_req), 0);
    wait_to(t0, cyc_of(RMAX_NS));
    chk("R12 raised", int'(pre_req), 4);
    issue(PRE, 2, "R12 pre", t1);
    chk("R12 cleared", int'(pre_req), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule